// File: doc/BRIEF.md
# Buffered SPI Master with Register Interface

This block is an SPI bus master that moves 8-bit words. Software drives it over a simple word-wide register port with separate read and write strobes. Bytes written to the transmit data register queue in a transmit FIFO. Each byte shifted out returns one byte from the serial input, and that byte queues in a receive FIFO that software drains through the receive data register.

A control register sets the clock polarity and phase, the enable and master gates, the chip-select policy, and a transmit-inhibit gate. The inhibit gate lets software preload several bytes and then release them as one burst. Two self-clearing control bits empty either FIFO. The serial clock half-period is a build-time parameter, `SCK_HALF`, counted in system clock cycles. Software cannot change it.

A status register reports the FIFO flags, a sticky receive overrun, and a sticky mode fault. The mode fault is raised when another master pulls the fault input low.

Register map (3-bit address): 0 control (read/write), 1 status (read only), 2 transmit data (write pushes), 3 receive data (read pops), 4 slave-select (read/write).

Top module: `spim_ctrl`

## Requirements
- R1: After reset the control register reads 0x0100 (inhibit set), status reads 0x0005 (both FIFOs empty), slave-select reads all ones, `ss_n` is all ones and `sck` is low.
- R2: A byte starts only while control bit 1 (enable) and bit 2 (master) are both set, bit 8 (inhibit) is clear and no mode fault is pending. With either gate bit clear, queued bytes produce no `sck` edge.
- R3: While bit 8 (inhibit) is set, the transmit FIFO keeps its data and no shifting starts. Clearing it drains the FIFO byte after byte.
- R4: Each byte goes out MSB first on `mosi` over 8 `sck` periods. The 8 bits sampled from `miso` are pushed as one byte into the receive FIFO, read at address 3 in order. Control bit 3 gives the idle `sck` level (CPOL). Control bit 4 (CPHA) selects where `miso` is sampled: 0 samples on the first edge of each bit, 1 on the second. Data changes on the other edge. All four modes work.
- R5: `sck` rests at the CPOL level between bytes and toggles every `SCK_HALF` clock cycles during a byte.
- R6: The transmit FIFO holds `FIFO_DEPTH` (16) bytes. A write to it when full is dropped. Status bit 2 means TX empty and bit 3 means TX full.
- R7: A received byte that finds the receive FIFO full is discarded, and status bit 5 (overrun) is set. The overrun flag stays set until a receive FIFO reset. Status bit 0 means RX empty and bit 1 means RX full.
- R8: Writing control bit 5 empties the transmit FIFO, and writing bit 6 empties the receive FIFO and clears overrun. Both bits read back as 0, and the other control bits take the written value.
- R9: With control bit 7 (manual select) set, `ss_n` equals the slave-select register at all times. With it clear, `ss_n` shows the slave-select register only while a byte is in flight, and is all ones otherwise.
- R10: `mf_n` low while enable and master are set raises status bit 4 (mode fault). The fault blocks new bytes until any control-register write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops receive data at address 3) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the strobe |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SS | Active-low slave selects |
| mf_n | input | 1 | Active-low mode-fault input from another master |

## Verification
The transfer path is run in all four polarity/phase combinations against a bench slave model. The slave answers with its own byte sequence, so swapped sample and launch edges, wrong bit order or a wrong idle level corrupt either the captured or the returned byte. Preloaded bursts with the inhibit gate held and then released separate gating errors from shifting errors. A seventeen-byte burst exercises both FIFO limits in one pass: the dropped write, the full flags and the overrun on the byte after. Chip-select checks in both select policies, gate-bit combinations and a mode-fault pulse show whether each control bit acts alone.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_TXD  = 3'd2;
  localparam logic [2:0] A_RXD  = 3'd3;
  localparam logic [2:0] A_SSEL = 3'd4;

  localparam int B_EN = 1, B_MST = 2, B_CPOL = 3, B_CPHA = 4;
  localparam int B_TXRST = 5, B_RXRST = 6, B_MAN = 7, B_INH = 8;

  typedef struct packed {
    logic inhibit;
    logic manual;
    logic cpha;
    logic cpol;
    logic master;
    logic enable;
  } ctrl_t;

  function automatic logic [15:0] ctrl_pack(ctrl_t c);
    logic [15:0] v;
    v = '0;
    v[B_EN] = c.enable;  v[B_MST] = c.master;
    v[B_CPOL] = c.cpol;  v[B_CPHA] = c.cpha;
    v[B_MAN] = c.manual; v[B_INH] = c.inhibit;
    return v;
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [15:0] v);
    ctrl_t c;
    c.enable = v[B_EN];  c.master = v[B_MST];
    c.cpol = v[B_CPOL];  c.cpha = v[B_CPHA];
    c.manual = v[B_MAN]; c.inhibit = v[B_INH];
    return c;
  endfunction

  function automatic logic [15:0] stat_pack(logic rx_e, logic rx_f, logic tx_e,
                                            logic tx_f, logic flt, logic ovr);
    return {10'd0, ovr, flt, tx_f, tx_e, rx_f, rx_e};
  endfunction

  // lead = first edge of a bit; data launches on the edge that is not sampled
  function automatic logic is_launch_edge(logic cpha, logic lead);
    return cpha ? lead : !lead;
  endfunction
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  logic                       pop,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH):0]     level
);
  localparam int unsigned PW = $clog2(DEPTH);
  localparam int unsigned CW = PW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  wire do_push = push && !full;
  wire do_pop  = pop && !empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp] <= din;
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign level = cnt;
endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
module spim_shift #(
  parameter int unsigned HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] din,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       miso,
  output logic       busy,
  output logic       sck,
  output logic       mosi,
  output logic       sck_edge,
  output logic       done,
  output logic [7:0] dout
);
  import spim_pkg::*;
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] tick;
  logic [3:0]    ecnt;
  logic [7:0]    tsh, rsh;
  logic          sck_r, mosi_r, busy_r, done_r, cpha_q;

  assign sck_edge = busy_r && (tick == CW'(HALF - 1));
  wire   lead     = !ecnt[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick <= '0; ecnt <= '0; tsh <= '0; rsh <= '0;
      sck_r <= 1'b0; mosi_r <= 1'b0; busy_r <= 1'b0; done_r <= 1'b0; cpha_q <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start && !busy_r) begin
        busy_r <= 1'b1;
        tick   <= '0;
        ecnt   <= '0;
        sck_r  <= cpol;
        cpha_q <= cpha;
        mosi_r <= din[7];
        tsh    <= cpha ? din : {din[6:0], 1'b0};
      end else if (busy_r) begin
        if (sck_edge) begin
          tick  <= '0;
          sck_r <= ~sck_r;
          ecnt  <= ecnt + 4'd1;
          if (is_launch_edge(cpha_q, lead)) begin
            mosi_r <= tsh[7];
            tsh    <= {tsh[6:0], 1'b0};
          end else begin
            rsh <= {rsh[6:0], miso};
          end
          if (ecnt == 4'd15) begin
            busy_r <= 1'b0;
            done_r <= 1'b1;
          end
        end else begin
          tick <= tick + CW'(1);
        end
      end
    end
  end

  assign busy = busy_r;
  assign sck  = busy_r ? sck_r : cpol;
  assign mosi = mosi_r;
  assign done = done_r;
  assign dout = rsh;
endmodule

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
module spim_ctrl #(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned NUM_SS     = 4,
  parameter int unsigned SCK_HALF   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [2:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  output logic [NUM_SS-1:0] ss_n,
  input  logic              mf_n
);
  import spim_pkg::*;
  localparam int unsigned LW = $clog2(FIFO_DEPTH) + 1;

  ctrl_t             ctrl_q;
  logic [NUM_SS-1:0] ssel_q;
  logic              fault_q, ovr_q;
  logic              busy, sck_edge, rx_push;
  logic [7:0]        tx_head, rx_head, rx_byte;
  logic              tx_empty, tx_full, rx_empty, rx_full;
  logic [LW-1:0]     tx_level, rx_level;

  wire wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
  wire wr_ssel  = bus_wr && (bus_addr == A_SSEL);
  wire tx_push  = bus_wr && (bus_addr == A_TXD);
  wire rx_pop   = bus_rd && (bus_addr == A_RXD);
  wire tx_flush = wr_ctrl && bus_wdata[B_TXRST];
  wire rx_flush = wr_ctrl && bus_wdata[B_RXRST];
  wire wdata_unused = ^bus_wdata;

  wire cfg_cpol    = ctrl_q.cpol;
  wire cfg_inhibit = ctrl_q.inhibit;
  wire run_ok      = ctrl_q.enable && ctrl_q.master && !cfg_inhibit && !fault_q;
  wire start       = run_ok && !tx_empty && !busy;
  wire rx_drop     = rx_push && rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= ctrl_unpack(16'h0100);
      ssel_q  <= '1;
      fault_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_unpack(bus_wdata);
      if (wr_ssel) ssel_q <= bus_wdata[NUM_SS-1:0];
      if (wr_ctrl)                                          fault_q <= 1'b0;
      else if (ctrl_q.enable && ctrl_q.master && !mf_n)     fault_q <= 1'b1;
      if (rx_flush)     ovr_q <= 1'b0;
      else if (rx_drop) ovr_q <= 1'b1;
    end
  end

  spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk(clk), .rst_n(rst_n), .flush(tx_flush), .push(tx_push), .pop(start),
    .din(bus_wdata[7:0]), .dout(tx_head), .empty(tx_empty), .full(tx_full),
    .level(tx_level));

  spim_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk(clk), .rst_n(rst_n), .flush(rx_flush), .push(rx_push), .pop(rx_pop),
    .din(rx_byte), .dout(rx_head), .empty(rx_empty), .full(rx_full),
    .level(rx_level));

  spim_shift #(.HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .din(tx_head), .cpol(cfg_cpol),
    .cpha(ctrl_q.cpha), .miso(miso), .busy(busy), .sck(sck), .mosi(mosi),
    .sck_edge(sck_edge), .done(rx_push), .dout(rx_byte));

  assign ss_n = (ctrl_q.manual || busy) ? ssel_q : '1;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata = ctrl_pack(ctrl_q);
      A_STAT: bus_rdata = stat_pack(rx_empty, rx_full, tx_empty, tx_full, fault_q, ovr_q);
      A_RXD:  bus_rdata = rx_empty ? 16'd0 : {8'd0, rx_head};
      A_SSEL: bus_rdata[NUM_SS-1:0] = ssel_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_chk.sv
`timescale 1ns/1ps
module spim_chk #(
  parameter int unsigned DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   busy,
  input logic                   sck,
  input logic                   cpol,
  input logic                   inhibit,
  input logic                   sck_edge,
  input logic [$clog2(DEPTH):0] tx_level,
  input logic [$clog2(DEPTH):0] rx_level,
  input logic                   rx_push,
  input logic                   rx_full,
  input logic                   rx_flush,
  input logic                   ovr
);
  AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol)); // R5
  AST_SCK_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !sck_edge |=> $stable(sck)); // R5
  AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit && !busy |=> !busy); // R3
  AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= ($clog2(DEPTH)+1)'(DEPTH)); // R6
  AST_RX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= ($clog2(DEPTH)+1)'(DEPTH)); // R7
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_full && !rx_flush |=> ovr); // R7
  AST_PUSH_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !busy); // R4
endmodule

bind spim_ctrl spim_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sck(sck), .cpol(cfg_cpol),
  .inhibit(cfg_inhibit), .sck_edge(sck_edge), .tx_level(tx_level),
  .rx_level(rx_level), .rx_push(rx_push), .rx_full(rx_full),
  .rx_flush(rx_flush), .ovr(ovr_q));

// File: tb/test_spim_ctrl.sv
`timescale 1ns/1ps
module test_spim_ctrl;
  localparam int HALF = 2;
  localparam logic [15:0] EN = 16'h02, MST = 16'h04, CPOL = 16'h08, CPHA = 16'h10;
  localparam logic [15:0] TXR = 16'h20, RXR = 16'h40, MAN = 16'h80, INH = 16'h100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0, bus_rdata;
  logic sck, mosi, miso, mf_n = 1'b1;
  logic [3:0] ss_n;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spim_ctrl #(.FIFO_DEPTH(16), .NUM_SS(4), .SCK_HALF(HALF)) i_spim_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi), .miso(miso),
    .ss_n(ss_n), .mf_n(mf_n));

  // ---------------- bench slave model ----------------
  bit s_on = 0, s_cpha = 0;
  int s_ecnt = 0, s_nbytes = 0;
  logic [7:0] s_out = 8'd0, s_in = 8'd0;
  logic [7:0] s_got [64];
  realtime s_last = 0.0, s_dt = 0.0;

  function automatic logic [7:0] resp(int i);
    return 8'h5A ^ 8'(i * 29);
  endfunction

  task automatic s_load(int i);
    logic [7:0] r;
    r = resp(i);
    if (!s_cpha) begin miso = r[7]; s_out = {r[6:0], 1'b0}; end
    else s_out = r;
  endtask

  task automatic arm(bit cpha);
    s_cpha = cpha; s_ecnt = 0; s_nbytes = 0;
    s_load(0);
    s_on = 1;
  endtask

  always @(sck) begin
    if (s_on) begin
      bit lead;
      lead = (s_ecnt % 2) == 0;
      if (s_cpha == lead) begin miso = s_out[7]; s_out = {s_out[6:0], 1'b0}; end
      else s_in = {s_in[6:0], mosi};
      s_dt = $realtime - s_last;
      s_last = $realtime;
      s_ecnt++;
      if (s_ecnt == 16) begin
        s_ecnt = 0;
        if (s_nbytes < 64) s_got[s_nbytes] = s_in;
        s_nbytes++;
        s_load(s_nbytes);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic wait_bytes(int n);
    for (int i = 0; i < 4000 && s_nbytes < n; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    logic [15:0] d;
    rd(3'd0, d); check("R1 ctrl", d, 16'h0100);
    rd(3'd1, d); check("R1 status", d, 16'h0005);
    rd(3'd4, d); check("R1 ssel", d, 16'h000F);
    check("R1 ss_n", ss_n, 4'hF);
    check("R1 sck", sck, 1'b0);
  endtask

  task automatic t_modes;
    logic [15:0] d, mb;
    wr(3'd4, 16'h000E);
    for (int m = 0; m < 4; m++) begin
      mb = (m[0] ? CPOL : 16'h0) | (m[1] ? CPHA : 16'h0);
      s_on = 0;
      wr(3'd0, INH | EN | MST | mb);
      arm(m[1]);
      for (int k = 0; k < 3; k++) wr(3'd2, 16'(8'h81 + m * 16 + k));
      wr(3'd0, EN | MST | mb);
      idle(10);
      check("R9 auto select active", ss_n, 4'hE);
      wait_bytes(3);
      for (int k = 0; k < 3; k++) begin
        check("R4 mosi byte", s_got[k], 32'(8'(8'h81 + m * 16 + k)));
        rd(3'd3, d); check("R4 miso byte", d, 32'(resp(k)));
      end
      check("R5 half period ns", int'(s_dt), HALF * 4);
      check("R5 idle level", sck, m[0]);
      check("R9 auto select idle", ss_n, 4'hF);
      s_on = 0;
    end
  endtask

  task automatic t_inhibit;
    logic [15:0] d;
    wr(3'd0, INH | EN | MST);
    arm(0);
    wr(3'd2, 16'h00C1); wr(3'd2, 16'h00C2);
    idle(60);
    check("R3 no shift while inhibited", s_nbytes, 0);
    rd(3'd1, d); check("R3 tx held", d[2], 1'b0);
    wr(3'd0, EN | MST);
    wait_bytes(2);
    check("R3 drained", s_nbytes, 2);
    check("R3 second byte", s_got[1], 8'hC2);
    rd(3'd1, d); check("R3 tx empty after drain", d[2], 1'b1);
    rd(3'd3, d); rd(3'd3, d);
    s_on = 0;
  endtask

  task automatic t_full;
    logic [15:0] d;
    wr(3'd0, INH | EN | MST);
    arm(0);
    for (int k = 0; k < 17; k++) wr(3'd2, 16'(8'h10 + k));
    rd(3'd1, d); check("R6 tx full flag", d[3], 1'b1);
    wr(3'd0, EN | MST);
    wait_bytes(16); idle(80);
    check("R6 17th write dropped", s_nbytes, 16);
    check("R6 last kept byte", s_got[15], 8'h1F);
    rd(3'd1, d); check("R7 rx full flag", d[1], 1'b1);
    check("R7 no overrun yet", d[5], 1'b0);
    wr(3'd2, 16'h00EE);
    wait_bytes(17);
    rd(3'd1, d); check("R7 overrun set", d[5], 1'b1);
    rd(3'd3, d); check("R7 oldest byte kept", d, 32'(resp(0)));
    wr(3'd0, EN | MST | RXR);
    rd(3'd1, d); check("R8 rx emptied", d[0], 1'b1);
    check("R8 overrun cleared", d[5], 1'b0);
    rd(3'd0, d); check("R8 ctrl kept, reset bit reads 0", d, EN | MST);
    s_on = 0;
  endtask

  task automatic t_txreset;
    logic [15:0] d;
    wr(3'd0, INH | EN | MST);
    arm(0);
    for (int k = 0; k < 3; k++) wr(3'd2, 16'h0033);
    rd(3'd1, d); check("R8 tx loaded", d[2], 1'b0);
    wr(3'd0, INH | EN | MST | TXR);
    rd(3'd1, d); check("R8 tx emptied", d[2], 1'b1);
    rd(3'd0, d); check("R8 ctrl after tx reset", d, INH | EN | MST);
    rd(3'd4, d); check("R8 ssel untouched", d, 16'h000E);
    wr(3'd0, EN | MST);
    idle(80);
    check("R8 nothing sent after reset", s_nbytes, 0);
    s_on = 0;
  endtask

  task automatic t_manual;
    wr(3'd4, 16'h000B);
    wr(3'd0, INH | MAN);
    check("R9 manual follows ssel", ss_n, 4'hB);
    wr(3'd4, 16'h000F);
    check("R9 manual deselect", ss_n, 4'hF);
    wr(3'd4, 16'h0007);
    check("R9 manual other slave", ss_n, 4'h7);
    wr(3'd0, INH);
    check("R9 auto idle deselect", ss_n, 4'hF);
  endtask

  task automatic t_gate;
    wr(3'd0, EN);
    arm(0);
    wr(3'd2, 16'h0055);
    idle(60);
    check("R2 no master bit", s_nbytes, 0);
    wr(3'd0, MST);
    idle(60);
    check("R2 no enable bit", s_nbytes, 0);
    wr(3'd0, EN | MST);
    wait_bytes(1);
    check("R2 both set sends", s_got[0], 8'h55);
    s_on = 0;
  endtask

  task automatic t_fault;
    logic [15:0] d;
    wr(3'd0, EN | MST);
    rd(3'd3, d);
    arm(0);
    @(negedge clk); mf_n = 0; idle(2); mf_n = 1;
    rd(3'd1, d); check("R10 fault flag", d[4], 1'b1);
    wr(3'd2, 16'h0077);
    idle(60);
    check("R10 fault blocks", s_nbytes, 0);
    wr(3'd0, EN | MST);
    rd(3'd1, d); check("R10 fault cleared", d[4], 1'b0);
    wait_bytes(1);
    check("R10 resumes", s_got[0], 8'h77);
    s_on = 0;
  endtask

  initial begin
    miso = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(2);
    t_reset;
    t_modes;
    t_inhibit;
    t_full;
    t_txreset;
    t_manual;
    t_gate;
    t_fault;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule